// File: doc/BRIEF.md
# Asynchronous Bus Cycle Master

This block runs single read or write transfers on an external asynchronous bus with strobes and a two-bit size acknowledge. It produces its own bus clock, which inverts on every system clock cycle. Each system clock cycle is therefore one bus state. A bus clock cycle is a high state (S0, S2, S4, ...) followed by a low state (S1, S3, S5, ...). A request is taken only when the next state will be a high one, so S0 always falls in the high phase.

The slave ends a transfer by driving a non-zero acknowledge code, which also reports the width of its port. It can signal a fault on the bus-error line instead, optionally together with halt. All three inputs go through a two-flop synchronizer. The sequencer acts on them only at the falling bus-clock edges that close high states. Each acknowledge sample that reads zero adds one wait cycle, and there is no upper limit on how many are added. Read data comes straight from the pins one falling edge after the acknowledge. A bus error seen on that same later edge still turns the transfer into a fault. The core side gives a request with a valid/ready pair and gets back a one-cycle response carrying data, port code and error flag.

Cycle numbers below count system clock cycles, with cycle 0 being the S0 state of a transfer.

Top module: `async_bus_master`

## Requirements
- R1: While reset is applied, and in the cycle after a reset that arrives during a transfer, bus_as, bus_ds, bus_doe and rsp_valid are low and req_ready is high. bus_clk is low while reset is held.
- R2: bus_clk inverts on every clk cycle once reset is released. An accepted request enters S0 with bus_clk high.
- R3: bus_as is high from S1 through S4. For a read, bus_ds is high in the same states as bus_as. For a write, bus_ds is high only in S3 and S4, and bus_doe drives bus_dout whenever bus_as is high.
- R4: Termination inputs are sampled only at falling bus_clk edges, after two synchronizer stages. An acknowledge present on the pins from cycle 0 is recognised at the edge that ends S2, and the response follows in cycle 6.
- R5: A zero acknowledge code (00) at a sampling edge adds one wait cycle (two states), with no limit. An acknowledge first driven in cycle j gives ceil(j/2) wait cycles, so bus_as stays high for 4+2·ceil(j/2) cycles.
- R6: Read data is taken from bus_din at the falling edge that ends S4, one falling edge after the acknowledge. rsp_valid is a one-cycle pulse in the cycle after S5.
- R7: rsp_port returns the recognised acknowledge code: 01 means a byte port, and 10 or 11 means a word port.
- R8: A bus error seen at the S2 or a wait-state sampling edge ends the transfer, with or without halt and with or without an acknowledge. S5 follows at once, and the response has rsp_err=1, rsp_port=00 and rsp_rdata=0.
- R9: A bus error first seen at the falling edge that ends S4 overrides an acknowledge already recognised, giving rsp_err=1, rsp_port=00 and rsp_rdata=0.
- R10: Halt on its own neither ends a transfer nor changes its length.
- R11: After S5, req_ready stays low until the synchronized acknowledge, bus error and halt all read inactive. Inputs that go idle in cycle r give req_ready high in cycle max(r, S5)+3.
- R12: bus_addr, bus_siz (loaded from req_size, and decoded by the slave together with address bit 0 to pick byte lanes), bus_rw (1 means read) and bus_dout hold steady while bus_as is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one period per bus state |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core has a transfer to run |
| req_ready | output | 1 | Master is idle and can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_size | input | 2 | Operand size code driven on bus_siz |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read data (0 on error or write) |
| rsp_port | output | 2 | Acknowledged port code (00 on error) |
| rsp_err | output | 1 | Transfer ended by bus error |
| bus_clk | output | 1 | Bus clock, half period = one clk cycle |
| bus_addr | output | ADDR_W | Bus address |
| bus_siz | output | 2 | Bus size code |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_as | output | 1 | Address strobe (active high) |
| bus_ds | output | 1 | Data strobe (active high) |
| bus_dout | output | DATA_W | Write data to bus |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | DATA_W | Read data from bus |
| bus_dsack | input | 2 | Size acknowledge code (active high) |
| bus_berr | input | 1 | Bus error (active high) |
| bus_halt | input | 1 | Halt (active high) |

## Verification
Two cases are hard to reach: a late bus error that must land exactly on the falling edge that ends S4, and a zero-wait transfer despite two synchronizer stages. Both need stimulus timed to the cycle relative to S0, which no port reveals directly. The bench locates S0 as the first cycle in which req_ready drops after a request is offered. It then places acknowledge, bus-error, halt and data edges at computed cycle offsets: data is valid only during the S4 cycle, and the late error is raised two cycles before the sampling edge. Each response arrival and each return of req_ready is checked against the exact expected cycle.

// File: rtl/abm_pkg.sv
package abm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_S0,
    ST_S1,
    ST_S2,
    ST_WL,
    ST_WH,
    ST_S3,
    ST_S4,
    ST_S5,
    ST_REL
  } abm_state_e;

  localparam logic [1:0] ACK_NONE = 2'b00;

  // address strobe window: S1 up to and including S4
  function automatic logic as_window(input abm_state_e s);
    return (s == ST_S1) || (s == ST_S2) || (s == ST_WL) ||
           (s == ST_WH) || (s == ST_S3) || (s == ST_S4);
  endfunction

  // write data strobe window: S3 and S4 only
  function automatic logic late_ds_window(input abm_state_e s);
    return (s == ST_S3) || (s == ST_S4);
  endfunction

endpackage

// File: rtl/abm_sync.sv
module abm_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/abm_ctrl.sv
module abm_ctrl
  import abm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [1:0] ack_code,
  input  logic       berr_s,
  input  logic       halt_s,
  output logic       req_ready,
  output logic       bus_clk,
  output logic       bus_as,
  output logic       bus_ds,
  output logic       bus_doe,
  output logic       load,
  output logic       ack_take,
  output logic       data_take,
  output logic       err_take,
  output logic       done
);

  abm_state_e state, state_d;
  logic       wr_q;
  logic       wr_n;

  always_comb begin
    state_d   = state;
    load      = 1'b0;
    ack_take  = 1'b0;
    data_take = 1'b0;
    err_take  = 1'b0;
    done      = 1'b0;
    case (state)
      ST_IDLE: begin
        // start only when the coming state is a high phase
        if (req_valid && !bus_clk) begin
          load    = 1'b1;
          state_d = ST_S0;
        end
      end
      ST_S0: state_d = ST_S1;
      ST_S1: state_d = ST_S2;
      ST_S2, ST_WH: begin
        if (berr_s) begin
          err_take = 1'b1;
          state_d  = ST_S5;
        end else if (ack_code != ACK_NONE) begin
          ack_take = 1'b1;
          state_d  = ST_S3;
        end else begin
          state_d = ST_WL;
        end
      end
      ST_WL: state_d = ST_WH;
      ST_S3: state_d = ST_S4;
      ST_S4: begin
        if (berr_s) begin
          err_take = 1'b1;
        end else if (!wr_q) begin
          data_take = 1'b1;
        end
        state_d = ST_S5;
      end
      ST_S5: begin
        done    = 1'b1;
        state_d = ST_REL;
      end
      ST_REL: begin
        if ((ack_code == ACK_NONE) && !berr_s && !halt_s) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign wr_n = load ? req_write : wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wr_q      <= 1'b0;
      bus_clk   <= 1'b0;
      bus_as    <= 1'b0;
      bus_ds    <= 1'b0;
      bus_doe   <= 1'b0;
      req_ready <= 1'b1;
    end else begin
      state     <= state_d;
      wr_q      <= wr_n;
      bus_clk   <= ~bus_clk;
      bus_as    <= as_window(state_d);
      bus_ds    <= wr_n ? late_ds_window(state_d) : as_window(state_d);
      bus_doe   <= wr_n & as_window(state_d);
      req_ready <= (state_d == ST_IDLE);
    end
  end

  p_clk_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (bus_clk != $past(bus_clk)));

  p_ds_needs_as_r3: assert property (@(posedge clk) disable iff (rst)
    bus_ds |-> bus_as);

  p_as_rise_low_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_as) |-> !bus_clk);

  p_sample_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (ack_take || err_take || data_take) |-> bus_clk);

  p_ready_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!bus_as && !bus_ds && !bus_doe));

endmodule

// File: rtl/abm_dpath.sv
module abm_dpath #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ack_take,
  input  logic [1:0]        ack_code,
  input  logic              data_take,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              err_take,
  input  logic              done,
  input  logic              bus_as,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic              bus_rw,
  output logic [DATA_W-1:0] bus_dout,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_port,
  output logic              rsp_err
);

  logic [DATA_W-1:0] rdata_q;
  logic [1:0]        port_q;
  logic              err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      bus_siz  <= '0;
      bus_rw   <= 1'b1;
      bus_dout <= '0;
      rdata_q  <= '0;
      port_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      if (load) begin
        bus_addr <= req_addr;
        bus_siz  <= req_size;
        bus_rw   <= ~req_write;
        bus_dout <= req_wdata;
        rdata_q  <= '0;
        port_q   <= '0;
        err_q    <= 1'b0;
      end
      if (ack_take)  port_q  <= ack_code;
      if (data_take) rdata_q <= bus_din;
      if (err_take)  err_q   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_port  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= done;
      if (done) begin
        rsp_rdata <= err_q ? '0 : rdata_q;
        rsp_port  <= err_q ? 2'b00 : port_q;
        rsp_err   <= err_q;
      end
    end
  end

  p_addr_stable_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_as && $past(bus_as)) |->
      ($stable(bus_addr) && $stable(bus_siz) && $stable(bus_rw) && $stable(bus_dout)));

  p_rsp_single_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_err_clean_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> ((rsp_port == 2'b00) && (rsp_rdata == '0)));

endmodule

// File: rtl/async_bus_master.sv
module async_bus_master #(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_port,
  output logic              rsp_err,
  output logic              bus_clk,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic              bus_rw,
  output logic              bus_as,
  output logic              bus_ds,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  input  logic [1:0]        bus_dsack,
  input  logic              bus_berr,
  input  logic              bus_halt
);

  localparam int TERM_W = 4;

  logic [TERM_W-1:0] term_raw, term_s;
  logic [1:0]        ack_code;
  logic              berr_s, halt_s;
  logic              load, ack_take, data_take, err_take, done;

  assign term_raw = {bus_dsack, bus_berr, bus_halt};
  assign ack_code = term_s[3:2];
  assign berr_s   = term_s[1];
  assign halt_s   = term_s[0];

  abm_sync #(
    .WIDTH  (TERM_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (term_raw),
    .q   (term_s)
  );

  abm_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .ack_code  (ack_code),
    .berr_s    (berr_s),
    .halt_s    (halt_s),
    .req_ready (req_ready),
    .bus_clk   (bus_clk),
    .bus_as    (bus_as),
    .bus_ds    (bus_ds),
    .bus_doe   (bus_doe),
    .load      (load),
    .ack_take  (ack_take),
    .data_take (data_take),
    .err_take  (err_take),
    .done      (done)
  );

  abm_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .ack_take  (ack_take),
    .ack_code  (ack_code),
    .data_take (data_take),
    .bus_din   (bus_din),
    .err_take  (err_take),
    .done      (done),
    .bus_as    (bus_as),
    .bus_addr  (bus_addr),
    .bus_siz   (bus_siz),
    .bus_rw    (bus_rw),
    .bus_dout  (bus_dout),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_port  (rsp_port),
    .rsp_err   (rsp_err)
  );

endmodule

// File: tb/async_bus_master_test.sv
`timescale 1ns/1ps
module async_bus_master_test;

  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [1:0]    rsp_port;
  logic          rsp_err;
  logic          bus_clk;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_siz;
  logic          bus_rw;
  logic          bus_as;
  logic          bus_ds;
  logic [DW-1:0] bus_dout;
  logic          bus_doe;
  logic [DW-1:0] bus_din = '0;
  logic [1:0]    bus_dsack = '0;
  logic          bus_berr = 1'b0;
  logic          bus_halt = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  async_bus_master uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_port(rsp_port), .rsp_err(rsp_err),
    .bus_clk(bus_clk), .bus_addr(bus_addr), .bus_siz(bus_siz), .bus_rw(bus_rw),
    .bus_as(bus_as), .bus_ds(bus_ds), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_dsack(bus_dsack), .bus_berr(bus_berr), .bus_halt(bus_halt)
  );

  // mode: 0 ack only, 1 early bus error, 2 late bus error, 3 error and ack together
  typedef struct packed {
    logic        wr;
    logic [5:0]  j;
    logic [1:0]  code;
    logic [1:0]  mode;
    logic [5:0]  hrel;
    logic [1:0]  siz;
    logic [7:0]  alo;
    logic [15:0] data;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd0,  2'b10, 2'd0, 6'd0,  2'b10, 8'h10, 16'h5AC3},
    '{1'b0, 6'd0,  2'b01, 2'd0, 6'd0,  2'b01, 8'h11, 16'h00A7},
    '{1'b0, 6'd1,  2'b11, 2'd0, 6'd0,  2'b10, 8'h20, 16'h1234},
    '{1'b1, 6'd0,  2'b10, 2'd0, 6'd0,  2'b10, 8'h32, 16'hBEEF},
    '{1'b1, 6'd3,  2'b01, 2'd0, 6'd0,  2'b01, 8'h41, 16'h0055},
    '{1'b0, 6'd40, 2'b10, 2'd0, 6'd0,  2'b00, 8'h50, 16'h7E81},
    '{1'b0, 6'd0,  2'b00, 2'd1, 6'd0,  2'b10, 8'h60, 16'h9999},
    '{1'b0, 6'd5,  2'b00, 2'd1, 6'd0,  2'b10, 8'h62, 16'h4242},
    '{1'b0, 6'd0,  2'b10, 2'd2, 6'd0,  2'b10, 8'h70, 16'hC0DE},
    '{1'b1, 6'd2,  2'b11, 2'd2, 6'd0,  2'b11, 8'h73, 16'hF00D},
    '{1'b0, 6'd4,  2'b10, 2'd0, 6'd10, 2'b10, 8'h80, 16'h3C3C},
    '{1'b0, 6'd0,  2'b01, 2'd0, 6'd30, 2'b01, 8'h81, 16'h6B6B},
    '{1'b0, 6'd2,  2'b00, 2'd1, 6'd20, 2'b10, 8'h90, 16'h1111},
    '{1'b0, 6'd3,  2'b10, 2'd3, 6'd0,  2'b10, 8'hA0, 16'h2222}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    bit early, late;
    int j, w, s5, rsp_exp, as_exp, ds_exp, hd, ready_exp, port_exp, rdata_exp, err_exp;
    int cyc, as_n, ds_n, rsp_cyc, ready_cyc, r_data, r_port, r_err, clk0;
    bit seen_as, released, bad_bus;
    logic [AW-1:0] a_exp;
    early = (v.mode == 2'd1) || (v.mode == 2'd3);
    late  = (v.mode == 2'd2);
    j     = int'(v.j);
    w     = (j + 1) / 2;
    s5        = early ? 3 + 2*w : 5 + 2*w;
    rsp_exp   = s5 + 1;
    as_exp    = early ? 2 + 2*w : 4 + 2*w;
    ds_exp    = v.wr ? (early ? 0 : 2) : as_exp;
    hd        = int'(v.hrel);
    ready_exp = ((hd > s5) ? hd : s5) + 3;
    err_exp   = (early || late) ? 1 : 0;
    port_exp  = err_exp ? 0 : int'(v.code);
    rdata_exp = (err_exp || v.wr) ? 0 : int'(v.data);
    a_exp     = {16'h12C4, v.alo};

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = v.wr;
    req_addr  = a_exp;
    req_size  = v.siz;
    req_wdata = v.data;
    do @(negedge clk); while (req_ready);
    req_valid = 1'b0;
    clk0 = int'(bus_clk);

    cyc = 0; as_n = 0; ds_n = 0; seen_as = 0; released = 0; bad_bus = 0;
    rsp_cyc = -1; ready_cyc = -1; r_data = -1; r_port = -1; r_err = -1;
    while (cyc < 200 && ready_cyc < 0) begin
      if (bus_as) begin
        as_n++;
        seen_as = 1;
        if (bus_addr != a_exp || bus_siz != v.siz || bus_rw != !v.wr) bad_bus = 1;
        if (v.wr && (!bus_doe || bus_dout != v.data)) bad_bus = 1;
      end
      if (bus_ds) ds_n++;
      if (seen_as && !bus_as) released = 1;
      if (rsp_valid) begin
        rsp_cyc = cyc;
        r_data  = int'(rsp_rdata);
        r_port  = int'(rsp_port);
        r_err   = int'(rsp_err);
      end
      if (cyc > 0 && req_ready) ready_cyc = cyc;
      bus_dsack = (!released && v.mode != 2'd1 && cyc >= j) ? v.code : 2'b00;
      bus_berr  = !released && ((early && cyc >= j) || (late && cyc >= 2 + 2*w));
      bus_halt  = (hd != 0) && (cyc < hd);
      bus_din   = (cyc == 4 + 2*w) ? v.data : ~v.data;
      cyc++;
      @(negedge clk);
    end
    bus_dsack = 2'b00; bus_berr = 1'b0; bus_halt = 1'b0;

    check(clk0 == 1, $sformatf("R2 vec%0d S0 in high phase", idx), clk0, 1);
    check(rsp_cyc == rsp_exp, $sformatf("R4/R5/R10 vec%0d response cycle", idx), rsp_cyc, rsp_exp);
    check(as_n == as_exp, $sformatf("R3/R5 vec%0d AS length", idx), as_n, as_exp);
    check(ds_n == ds_exp, $sformatf("R3 vec%0d DS length", idx), ds_n, ds_exp);
    check(!bad_bus, $sformatf("R12 vec%0d address/size/dir/data held", idx), int'(bad_bus), 0);
    check(r_err == err_exp, $sformatf("R8/R9 vec%0d error flag", idx), r_err, err_exp);
    check(r_port == port_exp, $sformatf("R7 vec%0d port code", idx), r_port, port_exp);
    check(r_data == rdata_exp, $sformatf("R6 vec%0d read data", idx), r_data, rdata_exp);
    check(ready_cyc == ready_exp, $sformatf("R11 vec%0d ready return", idx), ready_cyc, ready_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R5 watchdog expired: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int c1, c2;
    // R1: state held in reset
    repeat (3) @(negedge clk);
    check(bus_clk == 1'b0, "R1 bus_clk in reset", int'(bus_clk), 0);
    check(!bus_as && !bus_ds && !bus_doe, "R1 strobes in reset", int'({bus_as, bus_ds, bus_doe}), 0);
    check(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 no response in reset", int'(rsp_valid), 0);
    rst = 1'b0;
    // R2: free-running bus clock
    @(negedge clk); c1 = int'(bus_clk);
    @(negedge clk); c2 = int'(bus_clk);
    check(c1 != c2, "R2 bus_clk toggles", c2, 1 - c1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R1: reset during an active transfer
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h00ABCD; req_size = 2'b10;
    do @(negedge clk); while (req_ready);
    req_valid = 1'b0;
    while (!bus_as) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!bus_as && !bus_ds && !bus_doe, "R1 strobes after mid-transfer reset",
          int'({bus_as, bus_ds, bus_doe}), 0);
    check(req_ready == 1'b1, "R1 ready after mid-transfer reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 no response after mid-transfer reset", int'(rsp_valid), 0);
    rst = 1'b0;

    // a clean transfer right after the reset still runs zero-wait
    run_vec(VECS[0], 100);

    summary();
    $finish;
  end

endmodule